// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block generates the two external-bus timing strobes of an 8-bit microcontroller core whose machine cycle lasts 12 oscillator periods. The machine cycle is divided into six states, and each state has two phases. The block runs directly on the oscillator clock. It steps through the states and drives two outputs:

- the address-latch strobe (`ale`, active high);
- the program-store read strobe (`psen_n`, active low).

The core tells the block what kind of machine cycle comes next: a code fetch, an external data access, or a code-table read. It also reports whether code is currently executing from external program memory. On an external data cycle the block drops the second address-latch pulse and both program-read pulses.

A one-bit control register holds an address-latch disable flag. When the flag is set, the address-latch output stays high and stops toggling, except during data or table-read cycles. The flag has no effect while code runs from external memory. The register is reached through a simple byte-wide register write/read port.

Top module: `ext_strobe_seq`

## Requirements
- R1: While `rst_n` is low, `ale` is 0 and `psen_n` is 1. In the first cycle after release, `state`=1 and `phase`=0. The disable flag is cleared, so reading address 8'h8E returns 8'hFE.
- R2: The state and phase sequence advances as follows:
  - `phase` toggles every clock.
  - `state` advances by one after `phase`=1, and goes from 6 back to 1.
  - The sequence is 12 clocks per machine cycle.
- R3: On a code-fetch cycle with the disable flag clear, `ale` is 1 in states 1 and 4 and 0 elsewhere. This gives two clocks high out of every six.
- R4: On an external data cycle (`cyc_type`=2'b01), the state 1 pulse is kept, the state 4 pulse is omitted, and `ale` is 0 in states 2 to 6.
- R5: On a code-fetch cycle with external execution latched, `psen_n` is 0 in these slots and 1 elsewhere:
  - state 2 phase 1;
  - all of state 3;
  - state 5 phase 1;
  - all of state 6.
- R6: On an external data cycle, `psen_n` stays 1 for all 12 clocks.
- R7: `cyc_type` and `ext_exec` are sampled on the clock edge that ends state 6 phase 1. They apply unchanged to the whole following cycle. The value 2'b11 counts as a code fetch. During reset, the cycle type is forced to code fetch and `ext_exec` is sampled.
- R8: With the disable flag set and internal execution, a code-fetch cycle holds `ale` at 1 for all 12 clocks.
- R9: With the disable flag set and internal execution, data cycles and table-read cycles still produce their normal `ale` pulses.
- R10: With external execution latched, the disable flag has no effect on `ale`.
- R11: On a table-read cycle (`cyc_type`=2'b10), `ale` pulses in states 1 and 4. `psen_n` follows the R5 pattern when external execution is latched, and stays 1 otherwise.
- R12: A write with `sfr_we`=1 and `sfr_addr`=8'h8E stores only `sfr_wdata` bit 0 as the disable flag. Reading that address returns {7'b1111111, flag}. Writes to other addresses change nothing, and reads of them return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_type | input | 2 | Next machine-cycle kind: 00 fetch, 01 external data, 10 table read, 11 fetch |
| ext_exec | input | 1 | Core executes from external program memory |
| sfr_we | input | 1 | Register write enable |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| state | output | 3 | Current state, 1 to 6 |
| phase | output | 1 | Current phase within the state, 0 or 1 |

## Verification
The hardest case to reach from the ports is an input change in the middle of a machine cycle. The new cycle type or execution mode must not affect the current cycle; it may only take effect at the next cycle boundary. The bench tracks the cycle position in its own model and waits for state 3. It then switches `cyc_type` to a data cycle and confirms that the state 4 pulse still appears. It also writes the disable flag part-way through a fetch cycle and checks that the effect starts on the very next clock. After these directed steps comes a random run. That run mixes all four cycle codes, both execution modes, and register writes to the control address and to other addresses.

// File: rtl/ext_strobe_seq.sv
module ext_strobe_seq #(
  parameter logic [7:0] CTRL_ADDR = 8'h8E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cyc_type,
  input  logic       ext_exec,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       ale,
  output logic       psen_n,
  output logic [2:0] state,
  output logic       phase
);
  localparam logic [1:0] CT_FETCH = 2'b00;
  localparam logic [1:0] CT_DATA  = 2'b01;
  localparam logic [1:0] CT_TABLE = 2'b10;
  localparam logic [2:0] ST_FIRST = 3'd1;
  localparam logic [2:0] ST_LAST  = 3'd6;

  logic [2:0] st;
  logic       ph;
  logic [1:0] cur_type;
  logic       cur_ext;
  logic       ale_dis;
  logic       cyc_end;

  assign cyc_end = (st == ST_LAST) && ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_FIRST;
      ph       <= 1'b0;
      cur_type <= CT_FETCH;
      cur_ext  <= ext_exec;
      ale_dis  <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) st <= (st == ST_LAST) ? ST_FIRST : st + 3'd1;
      if (cyc_end) begin
        cur_type <= (cyc_type == CT_DATA || cyc_type == CT_TABLE) ? cyc_type : CT_FETCH;
        cur_ext  <= ext_exec;
      end
      if (sfr_we && sfr_addr == CTRL_ADDR)
        ale_dis <= (sfr_wdata & 8'h01) != 8'h00;
    end
  end

  logic pulse_slot, ale_hold, psen_slot;

  assign pulse_slot = (st == 3'd1) || (st == 3'd4 && cur_type != CT_DATA);
  assign ale_hold   = ale_dis && !cur_ext && cur_type == CT_FETCH;
  assign psen_slot  = (st == 3'd2 && ph) || st == 3'd3 || (st == 3'd5 && ph) || st == 3'd6;

  assign ale       = rst_n && (ale_hold || pulse_slot);
  assign psen_n    = !(rst_n && cur_ext && cur_type != CT_DATA && psen_slot);
  assign state     = st;
  assign phase     = ph;
  assign sfr_rdata = (sfr_addr == CTRL_ADDR) ? {7'h7F, ale_dis} : 8'h00;
endmodule

module strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic [2:0] state,
  input logic       phase,
  input logic [1:0] cur_type,
  input logic       cur_ext,
  input logic       ale_dis
);
  always @(posedge clk) begin
    // R1
    if (!rst_n) reset_idle_chk: assert (!ale && psen_n);
  end

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> phase);

  // R2
  state_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && phase) |=> (state == 3'd1 && !phase));

  // R4
  data_ale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_type == 2'b01 && state >= 3'd2) |-> !ale);

  // R5
  psen_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (state == 3'd3 || state == 3'd6 || (state == 3'd2 && phase) || (state == 3'd5 && phase)));

  // R6
  data_psen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_type == 2'b01 |-> psen_n);

  // R8
  ale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_dis && !cur_ext && cur_type == 2'b00) |-> ale);

  // R10
  ext_ignores_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ext && cur_type == 2'b00 && state == 3'd2) |-> !ale);
endmodule

bind ext_strobe_seq strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .state(state), .phase(phase),
  .cur_type(cur_type), .cur_ext(cur_ext), .ale_dis(ale_dis)
);

// File: tb/test_ext_strobe_seq.sv
module test_ext_strobe_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_type = 2'b00;
  logic       ext_exec = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       ale, psen_n;
  logic [2:0] state;
  logic       phase;

  ext_strobe_seq i_ext_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .ext_exec(ext_exec),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ale(ale), .psen_n(psen_n), .state(state), .phase(phase)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model: position in cycle 0..11, latched kind, mode and flag
  int m_t = 0;
  int m_type = 0;
  bit m_ext = 0;
  bit m_dis = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = 0; m_type = 0; m_ext = ext_exec; m_dis = 0;
    end else begin
      if (sfr_we && sfr_addr == 8'h8E) m_dis = sfr_wdata[0];
      if (m_t == 11) begin
        m_t = 0;
        m_type = (cyc_type == 2'b11) ? 0 : int'(cyc_type);
        m_ext = ext_exec;
      end else m_t++;
    end
  end

  function automatic bit exp_ale();
    bit p;
    if (!rst_n) return 1'b0;
    p = (m_t < 2) || ((m_t == 6 || m_t == 7) && m_type != 1);
    if (m_dis && !m_ext && m_type == 0) return 1'b1;
    return p;
  endfunction

  function automatic bit exp_psen_n();
    if (!rst_n) return 1'b1;
    return !(m_ext && m_type != 1 && (m_t inside {3, 4, 5, 9, 10, 11}));
  endfunction

  function automatic string ale_tag();
    if (!rst_n) return "R1";
    if (m_type == 1) return "R4";
    if (m_dis && !m_ext && m_type != 0) return "R9";
    if (m_type == 2) return "R11";
    if (m_dis && !m_ext) return "R8";
    if (m_dis && m_ext) return "R10";
    return "R3";
  endfunction

  function automatic string psen_tag();
    if (!rst_n) return "R1";
    if (m_type == 1) return "R6";
    if (m_type == 2) return "R11";
    return "R5";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!done) begin
      check(ale_tag(), "ale", int'(ale), int'(exp_ale()));
      check(psen_tag(), "psen_n", int'(psen_n), int'(exp_psen_n()));
      if (rst_n) begin
        check("R2", "state", int'(state), m_t / 2 + 1);
        check("R2", "phase", int'(phase), m_t % 2);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_t(input int t);
    do @(negedge clk); while (m_t != t);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a;
    #1;
    check(req, "sfr_rdata", int'(sfr_rdata), int'(exp));
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    // R1: disable flag cleared by reset
    sfr_read("R1", 8'h8E, 8'hFE);
    cycles(36);                         // R3 internal fetch
    ext_exec = 1'b1;
    cycles(36);                         // R5
    wait_t(11); cyc_type = 2'b01;       // R4, R6 data cycle
    wait_t(11); cyc_type = 2'b10;       // R11 table read, external
    wait_t(11); cyc_type = 2'b11;       // R7 code 11 counts as fetch
    wait_t(11); cyc_type = 2'b00; ext_exec = 1'b0;
    wait_t(11); cyc_type = 2'b10;       // R11 internal table read
    wait_t(11); cyc_type = 2'b00;
    // R7: mid-cycle change must not alter current fetch cycle
    wait_t(4); cyc_type = 2'b01;
    wait_t(6);
    check("R7", "ale state4 after mid-cycle change", int'(ale), 1);
    wait_t(0);
    cyc_type = 2'b00;
    wait_t(6);
    check("R7", "ale state4 in sampled data cycle", int'(ale), 0);
    // R8: disable flag written mid-cycle
    wait_t(3);
    sfr_write(8'h8E, 8'h01);
    sfr_read("R12", 8'h8E, 8'hFF);
    check("R8", "ale held high", int'(ale), 1);
    cycles(24);
    wait_t(11); cyc_type = 2'b01;       // R9
    wait_t(11); cyc_type = 2'b10;       // R9
    wait_t(11); cyc_type = 2'b00; ext_exec = 1'b1;  // R10
    wait_t(11); ext_exec = 1'b1;
    wait_t(2);
    check("R10", "ale low in state 2", int'(ale), 0);
    ext_exec = 1'b0;
    // R12: other addresses ignored
    sfr_write(8'h8F, 8'h00);
    sfr_write(8'h0E, 8'h00);
    sfr_read("R12", 8'h8E, 8'hFF);
    sfr_read("R12", 8'h8F, 8'h00);
    sfr_write(8'h8E, 8'hFE);            // only bit 0 stored
    sfr_read("R12", 8'h8E, 8'hFE);
    sfr_write(8'h8E, 8'h03);
    cycles(30);
    // R1: reset mid-run
    wait_t(7);
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    sfr_read("R1", 8'h8E, 8'hFE);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc_type = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 20) == 0) ext_exec = ~ext_exec;
      sfr_we = ($urandom_range(0, 15) == 0);
      sfr_addr = $urandom_range(0, 1) ? 8'h8E : 8'($urandom_range(0, 255));
      sfr_wdata = 8'($urandom_range(0, 255));
    end
    sfr_we = 1'b0;
    cycles(13);
    finish_run();
  end
endmodule